// File: doc/BRIEF.md
# Ring transmit credit tracker

This block sits in a sending station of a message ring and decides, cycle by cycle, whether the station may put a message on the ring. Every destination on the ring is a bucket named by a global index. The tracker keeps one credit counter per bucket. Software loads each counter with the number of messages this station may have outstanding toward that bucket. The sum of such loads across all senders must not exceed the bucket's capacity at the receiver, and that rule is what protects the receiver from overflow.

A send request names a destination bucket. It is granted in the same cycle when that bucket still holds at least one credit, and each grant consumes one credit. When the receiver drains a message, the ring returns a credit pulse naming the bucket, and the counter goes back up by one. A bucket that software never loaded holds zero credits, so every request to it is refused. Configuration writes replace a counter outright. Returns still in flight are not tracked, so software should load counters only while traffic toward that bucket is quiet.

Top module: `ring_tx_credit_tracker`

## Requirements
- R1: After reset every bucket holds zero credits, so a request to any bucket (including index 0 and index 127) is refused.
- R2: `send_gnt` is 1 in exactly those cycles where `send_req` is 1 and the bucket on `send_bucket` holds a nonzero count. It is combinational within the cycle.
- R3: Each granted request lowers the addressed bucket's count by one at the next clock edge. A bucket loaded with N gives exactly N grants and then refuses.
- R4: A `ret_valid` pulse raises the named bucket's count by one at the next clock edge. A return that would lift a count above the value last loaded for that bucket is a protocol violation.
- R5: A grant and a return naming the same bucket in the same cycle leave that bucket's count unchanged.
- R6: A configuration write sets the bucket's count, and its upper limit, to `cfg_credit`, whatever the count was. If a grant or return hits the same bucket in that cycle, the write wins. The grant output in that cycle still reflects the count held before the write.
- R7: Buckets are independent. Activity on one bucket never changes another, and a never-loaded bucket refuses every request.
- R8: With the default parameters, a counter holds values up to 63. A load of 32, the largest bucket size, yields exactly 32 grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bucket | input | IDX_W (7) | Bucket being loaded |
| cfg_credit | input | CNT_W (6) | Credit value to load |
| send_req | input | 1 | Request to send one message |
| send_bucket | input | IDX_W (7) | Destination bucket of the request |
| send_gnt | output | 1 | Request granted this cycle |
| ret_valid | input | 1 | Credit returned from the ring |
| ret_bucket | input | IDX_W (7) | Bucket whose credit is returned |

## Verification
The bench uses the default build: 128 buckets and 6-bit counters. With these values it can address the topmost index 127 and load the full 32-credit bucket size, then exhaust it grant by grant. The sizes are large enough to show that buckets far apart in the index space stay isolated. A reference model of integers per bucket is stepped alongside the design and checks the grant each cycle. This covers the directed corner cases and a long stretch of mixed legal traffic, with returns issued only while a bucket is below its loaded value.

// File: rtl/ring_credit_pkg.sv
package ring_credit_pkg;

  // Next value of one credit counter; a load takes priority over traffic.
  function automatic int unsigned credit_step(input int unsigned cur,
                                              input bit up, input bit down,
                                              input bit load, input int unsigned load_val);
    if (load) return load_val;
    if (up && !down) return cur + 1;
    if (down && !up) return cur - 1;
    return cur;
  endfunction

endpackage

// File: rtl/rtc_onehot_decode.sv
module rtc_onehot_decode #(
  parameter int N = 128,
  parameter int W = 7
) (
  input  logic         en,
  input  logic [W-1:0] idx,
  output logic [N-1:0] hot
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign hot[i] = en && (idx == W'(i));
  end
endmodule

// File: rtl/rtc_credit_slot.sv
module rtc_credit_slot
  import ring_credit_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             up,
  input  logic             down,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] lim
);
  logic [CNT_W-1:0] cnt_d;

  always_comb cnt_d = CNT_W'(credit_step(int'(cnt), up, down, load, int'(load_val)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      lim <= '0;
    end else begin
      cnt <= cnt_d;
      if (load) lim <= load_val;
    end
  end
endmodule

// File: rtl/ring_tx_credit_tracker.sv
module ring_tx_credit_tracker #(
  parameter int NUM_BKT = 128,
  parameter int CNT_W   = 6,
  parameter int IDX_W   = $clog2(NUM_BKT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_bucket,
  input  logic [CNT_W-1:0] cfg_credit,
  input  logic             send_req,
  input  logic [IDX_W-1:0] send_bucket,
  output logic             send_gnt,
  input  logic             ret_valid,
  input  logic [IDX_W-1:0] ret_bucket
);
  logic [CNT_W-1:0] cnt_q [NUM_BKT];
  logic [CNT_W-1:0] lim_q [NUM_BKT];
  logic [NUM_BKT-1:0] load_vec, up_vec, down_vec;
  logic gnt_fire;
  logic tgt_has_credit;

  assign tgt_has_credit = (cnt_q[send_bucket] != '0);
  assign gnt_fire       = send_req && tgt_has_credit;
  assign send_gnt       = gnt_fire;

  rtc_onehot_decode #(.N(NUM_BKT), .W(IDX_W)) u_dec_load (.en(cfg_we),    .idx(cfg_bucket),  .hot(load_vec));
  rtc_onehot_decode #(.N(NUM_BKT), .W(IDX_W)) u_dec_up   (.en(ret_valid), .idx(ret_bucket),  .hot(up_vec));
  rtc_onehot_decode #(.N(NUM_BKT), .W(IDX_W)) u_dec_down (.en(gnt_fire),  .idx(send_bucket), .hot(down_vec));

  for (genvar b = 0; b < NUM_BKT; b++) begin : g_slot
    rtc_credit_slot #(.CNT_W(CNT_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .load(load_vec[b]), .load_val(cfg_credit),
      .up(up_vec[b]), .down(down_vec[b]),
      .cnt(cnt_q[b]), .lim(lim_q[b])
    );
  end
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker #(
  parameter int NUM_BKT = 128,
  parameter int CNT_W   = 6,
  parameter int IDX_W   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [IDX_W-1:0] cfg_bucket,
  input logic [CNT_W-1:0] cfg_credit,
  input logic             send_req,
  input logic [IDX_W-1:0] send_bucket,
  input logic             send_gnt,
  input logic             ret_valid,
  input logic [IDX_W-1:0] ret_bucket,
  input logic [CNT_W-1:0] cnt_q [NUM_BKT],
  input logic [CNT_W-1:0] lim_q [NUM_BKT]
);
  logic wr_on_send, wr_on_ret, ret_on_send;
  assign wr_on_send  = cfg_we && (cfg_bucket == send_bucket);
  assign wr_on_ret   = cfg_we && (cfg_bucket == ret_bucket);
  assign ret_on_send = ret_valid && (ret_bucket == send_bucket);

  assert_gnt_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    send_gnt |-> send_req);

  assert_grant_decrements_R3: assert property (@(posedge clk) disable iff (!rst_n)
    send_gnt && !wr_on_send && !ret_on_send |=>
      cnt_q[$past(send_bucket)] == CNT_W'($past(cnt_q[send_bucket]) - 1'b1));

  assert_return_increments_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && !wr_on_ret && !(send_gnt && ret_on_send) |=>
      cnt_q[$past(ret_bucket)] == CNT_W'($past(cnt_q[ret_bucket]) + 1'b1));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && !wr_on_ret && !(send_gnt && ret_on_send) |->
      cnt_q[ret_bucket] < lim_q[ret_bucket]);

  assert_same_bucket_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    send_gnt && ret_on_send && !wr_on_send |=>
      cnt_q[$past(send_bucket)] == $past(cnt_q[send_bucket]));

  assert_load_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cnt_q[$past(cfg_bucket)] == $past(cfg_credit));
endmodule

bind ring_tx_credit_tracker rtc_checker #(.NUM_BKT(NUM_BKT), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bucket(cfg_bucket), .cfg_credit(cfg_credit),
  .send_req(send_req), .send_bucket(send_bucket), .send_gnt(send_gnt),
  .ret_valid(ret_valid), .ret_bucket(ret_bucket), .cnt_q(cnt_q), .lim_q(lim_q)
);

// File: tb/sim_ring_tx_credit_tracker.sv
`timescale 1ns/1ps
module sim_ring_tx_credit_tracker;
  localparam int NB = 128;
  localparam int CW = 6;
  localparam int IW = 7;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [IW-1:0] cfg_bucket = 0; logic [CW-1:0] cfg_credit = 0;
  logic send_req = 0; logic [IW-1:0] send_bucket = 0; logic send_gnt;
  logic ret_valid = 0; logic [IW-1:0] ret_bucket = 0;

  int checks = 0, errors = 0;
  int mcnt [NB];
  int mlim [NB];

  always #4 clk = ~clk;

  ring_tx_credit_tracker u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bucket(cfg_bucket), .cfg_credit(cfg_credit),
    .send_req(send_req), .send_bucket(send_bucket), .send_gnt(send_gnt),
    .ret_valid(ret_valid), .ret_bucket(ret_bucket)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: send_gnt actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock cycle: drive at the falling edge, check grant, then advance the model.
  task automatic step(bit rq, int sb, bit rv, int rb, bit we, int wb, int wv, string tag);
    bit exp_g;
    @(negedge clk);
    send_req = rq; send_bucket = IW'(sb);
    ret_valid = rv; ret_bucket = IW'(rb);
    cfg_we = we; cfg_bucket = IW'(wb); cfg_credit = CW'(wv);
    #1;
    exp_g = rq && (mcnt[sb] > 0);
    chk(tag, int'(send_gnt), int'(exp_g));
    @(posedge clk);
    if (exp_g && !(we && wb == sb)) mcnt[sb] -= 1;
    if (rv && !(we && wb == rb)) mcnt[rb] += 1;
    if (we) begin mcnt[wb] = wv; mlim[wb] = wv; end
    #1;
    send_req = 0; ret_valid = 0; cfg_we = 0;
  endtask

  task automatic load(int b, int v);
    step(0, 0, 0, 0, 1, b, v, "R6");
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) begin mcnt[i] = 0; mlim[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: everything empty after reset
    step(1, 0, 0, 0, 0, 0, 0, "R1");
    step(1, 127, 0, 0, 0, 0, 0, "R1");
    step(1, 64, 0, 0, 0, 0, 0, "R1");

    // R3 / R2: load 2, two grants then refusal
    load(3, 2);
    step(0, 3, 0, 0, 0, 0, 0, "R2");
    step(1, 3, 0, 0, 0, 0, 0, "R3");
    step(1, 3, 0, 0, 0, 0, 0, "R3");
    step(1, 3, 0, 0, 0, 0, 0, "R3");
    // R7: neighbour untouched, never-loaded bucket refuses
    step(1, 4, 0, 0, 0, 0, 0, "R7");
    step(1, 2, 0, 0, 0, 0, 0, "R7");

    // R4: return restores one credit
    step(0, 0, 1, 3, 0, 0, 0, "R4");
    step(1, 3, 0, 0, 0, 0, 0, "R4");
    step(1, 3, 0, 0, 0, 0, 0, "R4");

    // R5: grant and return together on one credit
    load(10, 1);
    step(1, 10, 1, 10, 0, 0, 0, "R5");
    step(1, 10, 0, 0, 0, 0, 0, "R5");
    step(1, 10, 0, 0, 0, 0, 0, "R5");

    // R6: write in same cycle as grant wins; also lowering a count
    load(20, 4);
    step(1, 20, 0, 0, 1, 20, 2, "R6");
    step(1, 20, 0, 0, 0, 0, 0, "R6");
    step(1, 20, 0, 0, 0, 0, 0, "R6");
    step(1, 20, 0, 0, 0, 0, 0, "R6");
    load(20, 0);
    step(1, 20, 0, 0, 0, 0, 0, "R6");

    // R8: full 32-credit bucket at the top index
    load(127, 32);
    for (int k = 0; k < 33; k++) step(1, 127, 0, 0, 0, 0, 0, "R8");
    step(1, 126, 0, 0, 0, 0, 0, "R7");

    // Mixed legal traffic over a few buckets (R2 every cycle)
    for (int b = 40; b < 48; b++) load(b, (b % 4 == 0) ? 2 : (b % 4 == 1) ? 4 : (b % 4 == 2) ? 8 : 16);
    for (int n = 0; n < 3000; n++) begin
      int sb, rb;
      bit rq, rv;
      sb = 40 + $urandom_range(0, 8);
      rb = 40 + $urandom_range(0, 7);
      rq = $urandom_range(0, 1);
      rv = ($urandom_range(0, 2) != 0) && (mcnt[rb] < mlim[rb]);
      step(rq, sb, rv, rb, 0, 0, 0, "R2");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule